// File: doc/BRIEF.md
# Critical-Conduction PFC Cycle Controller

This block generates the gate drive for a boost power-factor stage that runs in critical conduction mode. Analog comparators outside the block turn the inductor zero-current winding, the switch current sense, the on-time ramp and the feedback voltage into digital flags. The block uses those flags to decide when each switching cycle starts and when its on period ends.

A cycle starts when the zero-current winding voltage falls below its trigger level after having first risen above its arming level. If no such event comes, a restart watchdog starts the cycle instead. The on period ends at the earliest of these: the ramp-versus-control match, the ramp peak (maximum on-time), or a current-sense overlimit once a leading-edge blanking window has passed. Between pulses the block holds the timing ramp discharged. Overvoltage blocks new pulses. Undervoltage or a low enable switches the controller off. A one-cycle flag marks the first pulse after enable, for downstream sequencing.

Top module: `crm_pfc_ctrl`

## Requirements
- R1: Every comparator flag passes through two synchronising flops. The drive output rises on the third rising clock edge after a valid trigger input. It falls on the third rising clock edge after a stop input.
- R2: The zero-current trigger is a rising edge of `zcd_low_i`. It starts a pulse only if a rising edge of `zcd_arm_i` has come since the previous trigger. A trigger without prior arming is ignored, and every trigger consumes the arming.
- R3: While the controller is active and not blocked, a pulse starts by itself once `WDOG_CYC` cycles pass with no pulse start. The drive rises on the `WDOG_CYC+3`-th edge after undervoltage is released. Watchdog-started pulses repeat every `WDOG_CYC+1` cycles. The count clears on each pulse start, and while undervoltage is present or enable is low.
- R4: During the first `BLANK_CYC` cycles of each on period, `cs_over_i` is ignored. After that window it ends the pulse. With the overlimit held high, each pulse lasts exactly `BLANK_CYC+1` cycles.
- R5: A high `ramp_match_i` or `ramp_peak_i` ends the pulse.
- R6: `ramp_dis_o` is high whenever the drive is low and low while the drive is high.
- R7: While `ovp_i` is high, no new pulse starts and a pulse already running continues. Pulses resume once it clears.
- R8: A high `uvp_i` or a low `enable_i` forces the drive low and keeps it low.
- R9: Stop beats start. If a start event meets a ramp match or ramp peak in the same cycle, the drive stays low.
- R10: `first_pulse_o` is high for exactly one cycle, coinciding with the first drive rise after enable. It stays low on later pulses.
- R11: After reset, the drive is low, `ramp_dis_o` is high and `first_pulse_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Controller enable |
| zcd_arm_i | input | 1 | Zero-current winding above arming level |
| zcd_low_i | input | 1 | Zero-current winding below trigger level |
| cs_over_i | input | 1 | Switch current above limit |
| ramp_match_i | input | 1 | On-time ramp plus offset reached control level |
| ramp_peak_i | input | 1 | On-time ramp at its peak |
| ovp_i | input | 1 | Output overvoltage |
| uvp_i | input | 1 | Feedback undervoltage |
| drive_o | output | 1 | PFC switch drive |
| ramp_dis_o | output | 1 | Timing ramp discharge command |
| first_pulse_o | output | 1 | One-cycle mark of first pulse after enable |

## Verification
Two functions can fall in the same cycle: the start of a cycle from a zero-current trigger and the end of a pulse from a ramp match. To provoke the collision, the bench raises the trigger and the match flag at the same instant, after arming, so both reach the logic on the same edge. It then confirms that the drive never rises in the following cycles. The bench also checks the case where blanking and an overlimit overlap: a short overlimit that falls entirely inside the blanking window must leave the pulse running.

// File: rtl/crm_pfc_ctrl.sv
module crm_pfc_ctrl #(
  parameter int BLANK_CYC = 28,
  parameter int WDOG_CYC  = 45000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic zcd_arm_i,
  input  logic zcd_low_i,
  input  logic cs_over_i,
  input  logic ramp_match_i,
  input  logic ramp_peak_i,
  input  logic ovp_i,
  input  logic uvp_i,
  output logic drive_o,
  output logic ramp_dis_o,
  output logic first_pulse_o
);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam int WW = $clog2(WDOG_CYC + 1);

  logic [7:0] s1, s2;
  logic [1:0] zcd_prev;
  logic en_s, uvp_s, ovp_s, peak_s, match_s, cs_s, low_s, arm_s;
  logic armed_q, drive_q, seen_q, first_q;
  logic [BW-1:0] blank_cnt;
  logic [WW-1:0] wd_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      zcd_prev <= '0;
    end else begin
      s1 <= {enable_i, uvp_i, ovp_i, ramp_peak_i, ramp_match_i, cs_over_i, zcd_low_i, zcd_arm_i};
      s2 <= s1;
      zcd_prev <= {low_s, arm_s};
    end

  assign {en_s, uvp_s, ovp_s, peak_s, match_s, cs_s, low_s, arm_s} = s2;

  wire arm_rise   = arm_s & ~zcd_prev[0];
  wire trig_rise  = low_s & ~zcd_prev[1];
  wire active     = en_s & ~uvp_s;
  wire wd_done    = (wd_cnt == WW'(WDOG_CYC));
  wire blank_done = (blank_cnt == BW'(BLANK_CYC));
  wire kill       = match_s | peak_s;
  wire start      = active & ~ovp_s & ~drive_q & ~kill & ((armed_q & trig_rise) | wd_done);
  wire stop       = drive_q & (~active | kill | (cs_s & blank_done));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed_q   <= 1'b0;
      drive_q   <= 1'b0;
      blank_cnt <= '0;
      wd_cnt    <= '0;
      seen_q    <= 1'b0;
      first_q   <= 1'b0;
    end else begin
      if (trig_rise || !active) armed_q <= 1'b0;
      else if (arm_rise)        armed_q <= 1'b1;

      if (start)     drive_q <= 1'b1;
      else if (stop) drive_q <= 1'b0;

      if (start)                      blank_cnt <= '0;
      else if (drive_q && !blank_done) blank_cnt <= blank_cnt + 1'b1;

      if (!active || start) wd_cnt <= '0;
      else if (!wd_done)    wd_cnt <= wd_cnt + 1'b1;

      if (!en_s)      seen_q <= 1'b0;
      else if (start) seen_q <= 1'b1;
      first_q <= start & ~seen_q;
    end

  assign drive_o       = drive_q;
  assign ramp_dis_o    = ~drive_q;
  assign first_pulse_o = first_q;

  AST_BLANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_q && !blank_done && !kill && active) |=> drive_q); // R4
  AST_OVP_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (ovp_s && !drive_q) |=> !drive_q); // R7
  AST_UVP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_s || uvp_s) |=> !drive_q); // R8
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!drive_q && kill) |=> !drive_q); // R9
  AST_FIRST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    first_pulse_o |=> !first_pulse_o); // R10
  AST_FIRST_ROSE: assert property (@(posedge clk) disable iff (!rst_n)
    first_pulse_o |-> $rose(drive_q)); // R10
  AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_q) |-> $past(armed_q || wd_done)); // R2
endmodule

// File: tb/crm_pfc_ctrl_bench.sv
module crm_pfc_ctrl_bench;
  localparam int BLANK = 4;
  localparam int WDOG  = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en, arm, low, cs, match, peak, ovp, uvp;
  logic drive, rdis, first;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  crm_pfc_ctrl #(.BLANK_CYC(BLANK), .WDOG_CYC(WDOG)) u_crm_pfc_ctrl (
    .clk(clk), .rst_n(rst_n), .enable_i(en), .zcd_arm_i(arm), .zcd_low_i(low),
    .cs_over_i(cs), .ramp_match_i(match), .ramp_peak_i(peak), .ovp_i(ovp),
    .uvp_i(uvp), .drive_o(drive), .ramp_dis_o(rdis), .first_pulse_o(first));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic uvp_init);
    rst_n = 1'b0;
    en = 1; arm = 0; low = 0; cs = 0; match = 0; peak = 0; ovp = 0; uvp = uvp_init;
    step(3);
    rst_n = 1'b1;
    step(4);
  endtask

  task automatic arm_zcd();
    arm = 1; step(3);
    arm = 0; step(3);
  endtask

  task automatic trigger_expect(input string req, input int exp);
    low = 1; step(2);
    check(req, drive, 0);
    step(1);
    check(req, drive, exp);
    low = 0;
  endtask

  task automatic end_pulse();
    match = 1; step(3);
    match = 0; step(3);
  endtask

  task t_reset();
    do_reset(0);
    check("R11 drive", drive, 0);
    check("R11 ramp_dis", rdis, 1);
    check("R11 first", first, 0);
  endtask

  task t_arm_and_stop();
    do_reset(0);
    low = 1; step(6);
    check("R2 unarmed trigger", drive, 0);
    low = 0; step(3);
    arm_zcd();
    trigger_expect("R1 R2 start latency", 1);
    check("R10 first pulse", first, 1);
    check("R6 ramp released", rdis, 0);
    step(1);
    check("R10 one cycle", first, 0);
    match = 1; step(2);
    check("R1 stop latency", drive, 1);
    step(1);
    check("R5 match stop", drive, 0);
    check("R6 ramp held", rdis, 1);
    match = 0; step(3);
    arm_zcd();
    trigger_expect("R2 second start", 1);
    check("R10 not again", first, 0);
    end_pulse();
  endtask

  task t_peak();
    do_reset(0);
    arm_zcd();
    trigger_expect("R5 start", 1);
    peak = 1; step(3);
    check("R5 peak stop", drive, 0);
    peak = 0; step(3);
  endtask

  task t_blank();
    int w;
    do_reset(0);
    cs = 1;
    arm_zcd();
    trigger_expect("R4 start", 1);
    w = 1;
    while (drive && w < 50) begin step(1); if (drive) w++; end
    check("R4 width with overlimit", w, BLANK + 1);
    cs = 0; step(3);
    arm_zcd();
    trigger_expect("R4 start2", 1);
    cs = 1; step(1);
    cs = 0; step(5);
    check("R4 overlimit in blanking ignored", drive, 1);
    end_pulse();
  endtask

  task t_stop_prio();
    do_reset(0);
    arm_zcd();
    low = 1; match = 1;
    for (int i = 0; i < 8; i++) begin
      step(1);
      if (drive) break;
    end
    check("R9 stop beats start", drive, 0);
    low = 0; match = 0; step(3);
  endtask

  task t_ovp();
    do_reset(0);
    ovp = 1; step(3);
    arm_zcd();
    low = 1; step(6);
    check("R7 blocked", drive, 0);
    low = 0; ovp = 0; step(3);
    arm_zcd();
    trigger_expect("R7 resumes", 1);
    ovp = 1; step(5);
    check("R7 running pulse kept", drive, 1);
    end_pulse();
    ovp = 0; step(3);
    arm_zcd();
    trigger_expect("R7 resumes after clear", 1);
    end_pulse();
  endtask

  task t_uvp_wdog();
    int n, bad;
    do_reset(1);
    bad = 0;
    for (int i = 0; i < 300; i++) begin step(1); if (drive) bad++; end
    check("R8 uvp holds low", bad, 0);
    uvp = 0;
    n = 0;
    while (!drive && n < 1000) begin step(1); n++; end
    check("R3 first watchdog start", n, WDOG + 3);
    n = 0;
    for (int i = 1; i < 1000; i++) begin
      step(1);
      if (i == 1) match = 1;
      if (i == 4) match = 0;
      if (i > 4 && drive) begin n = i; break; end
    end
    check("R3 watchdog period", n, WDOG + 1);
    uvp = 1; step(3);
    check("R8 uvp ends pulse", drive, 0);
    uvp = 0;
    n = 0;
    while (!drive && n < 1000) begin step(1); n++; end
    check("R8 restart after uvp", drive, 1);
    en = 0; step(3);
    check("R8 enable low ends pulse", drive, 0);
    bad = 0;
    for (int i = 0; i < 300; i++) begin step(1); if (drive) bad++; end
    check("R8 disabled stays low", bad, 0);
  endtask

  initial begin
    t_reset();
    t_arm_and_stop();
    t_peak();
    t_blank();
    t_stop_prio();
    t_ovp();
    t_uvp_wdog();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule